// File: doc/BRIEF.md
# Relocatable Register-Window Address Decoder

This block watches a 16-bit CPU address bus and decides whether each access falls inside a 512-byte internal register window. It also controls where that window sits. The window's base lives in a small control register, and that register is itself part of the window. Software moves the whole window by writing a new base into it. The base can be any 2 KB boundary in the 64 KB space. The window fills only the lowest 512 bytes of the chosen 2 KB slot.

A two-state lock machine guards the control register. The state `LK_OPEN` is entered on reset. The transition `seal` leads from `LK_OPEN` to `LK_SEALED` and is taken on the first control-register write made in normal mode. The state `LK_SEALED` has a single transition, `hold`, which keeps it there until reset. In special mode, writes are always accepted and the lock state does not change.

A two-byte port pair at window offsets 0x008–0x009 can be taken out of the map. It is removed when the emulate-port input is set and the chip runs in expanded mode. This lets an external device answer those addresses. In single-chip mode the pair always stays mapped.

Top module: `regwin_decoder`

## Requirements
- R1: After reset the base is 0, so the window covers 0x0000–0x01FF, the control register reads 0x00 and the lock state is `LK_OPEN`.
- R2: `blk_sel` is high exactly when addr[15:11] equals the stored base and addr[10:9] equals 0, except for the port exclusion in R8. While `blk_sel` is high, `blk_offset` equals addr[8:0].
- R3: Addresses in the upper 1.5 KB of the selected 2 KB slot (addr[10:9] not 0) do not assert `blk_sel`.
- R4: In normal mode (`mode_special`=0), only the first control-register write after reset is accepted. That write seals the lock. Every later write is ignored until the next reset.
- R5: In special mode (`mode_special`=1), every control-register write is accepted and the lock state stays as it was. A write made in special mode therefore leaves a later first normal-mode write still able to take effect.
- R6: The control register sits at window offset 0x014. Its bits 7:3 hold base bits 15:11. Bits 2:1 always read as 0 and ignore writes. Bit 0 is a plain stored flag. `ctl_rdata` shows the register while `rd_en` is high and the address hits offset 0x014; otherwise it shows 0x00.
- R7: A new base takes effect on the cycle after the write edge. From then on the control register is reached at the new base + 0x014, and addresses under the old base no longer select.
- R8: The port pair is at offsets 0x008 and 0x009. When a window hit lands there, `port_sel` is high and `blk_sel` is high, unless `mode_expanded`=1 and `port_emul`=1. In that case both are low. With `mode_expanded`=0 the pair is always mapped.
- R9: Reads never change the lock state or the stored register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 16 | CPU address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| mode_expanded | input | 1 | 1 = expanded bus mode, 0 = single-chip |
| port_emul | input | 1 | Request to drop the port pair from the map |
| blk_sel | output | 1 | Access targets the register window |
| blk_offset | output | 9 | Offset inside the window (valid while blk_sel is high) |
| ctl_rdata | output | 8 | Control register readback |
| port_sel | output | 1 | Access targets the mapped port pair |

## Verification
The assertions check the following on every cycle:
- A sealed register holds its base against normal-mode writes.
- The first normal-mode write seals the lock, and cycles without a write keep the lock state.
- A special-mode write always lands.
- The reserved read bits stay zero.
- `port_sel` never appears without `blk_sel`, and the pair stays mapped in single-chip mode.

Only the bench scenarios can show the rest. These cover where the window actually moves after relocation, and that the old base goes dark. They also cover the 1.5 KB dead zone above the window, a special-mode write followed by a still-accepted normal write, and the removal of the port pair only under the expanded and emulate combination.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [0:0] {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/regwin_match.sv
module regwin_match #(
    parameter int ADDR_W = 16,
    parameter int SLOT_W = 11,
    parameter int WIN_W  = 9
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [ADDR_W-SLOT_W-1:0] base,
    output logic                   hit,
    output logic [WIN_W-1:0]       offset
);
    localparam int GAP_W = SLOT_W - WIN_W;

    logic slot_match;
    logic low_part;

    always_comb begin
        slot_match = (addr[ADDR_W-1:SLOT_W] == base);
        low_part   = (addr[SLOT_W-1:WIN_W] == {GAP_W{1'b0}});
        hit        = slot_match && low_part;
        offset     = addr[WIN_W-1:0];
    end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
    import regwin_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BASE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              special,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [BASE_W-1:0] base,
    output logic              flag,
    output lock_state_e       lock_state
);
    lock_state_e state_q, state_d;
    logic [BASE_W-1:0] base_q;
    logic flag_q;
    logic accept;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // transitions: seal (OPEN->SEALED), hold (SEALED->SEALED)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_hit && !special) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    // outputs of the machine: write acceptance
    always_comb begin
        accept = 1'b0;
        unique case (state_q)
            LK_OPEN:   accept = wr_hit;
            LK_SEALED: accept = wr_hit && special;
            default:   accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            flag_q <= 1'b0;
        end else if (accept) begin
            base_q <= wdata[DATA_W-1 -: BASE_W];
            flag_q <= wdata[0];
        end
    end

    assign base       = base_q;
    assign flag       = flag_q;
    assign lock_state = state_q;

    assert_sealed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_SEALED && !special) |=> $stable(base_q));
    assert_first_seal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && wr_hit && !special) |=> (state_q == LK_SEALED));
    assert_special_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (special && wr_hit) |=> (base_q == $past(wdata[DATA_W-1 -: BASE_W])));
    assert_no_write_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit) |=> ($stable(state_q) && $stable(base_q)));
endmodule

// File: rtl/regwin_port.sv
module regwin_port #(
    parameter int WIN_W    = 9,
    parameter int PORT_OFS = 8,
    parameter int PORT_CNT = 2
) (
    input  logic             hit,
    input  logic [WIN_W-1:0] offset,
    input  logic             expanded,
    input  logic             emul,
    output logic             blk_sel,
    output logic             port_sel
);
    localparam int PORT_END = PORT_OFS + PORT_CNT;

    logic in_pair;
    logic dropped;

    always_comb begin
        in_pair  = (int'(offset) >= PORT_OFS) && (int'(offset) < PORT_END);
        dropped  = expanded && emul;
        port_sel = hit && in_pair && !dropped;
        blk_sel  = hit && !(in_pair && dropped);
    end
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int SLOT_W   = 11,
    parameter int WIN_W    = 9,
    parameter int CTL_OFS  = 20,
    parameter int PORT_OFS = 8,
    parameter int PORT_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mode_special,
    input  logic              mode_expanded,
    input  logic              port_emul,
    output logic              blk_sel,
    output logic [WIN_W-1:0]  blk_offset,
    output logic [DATA_W-1:0] ctl_rdata,
    output logic              port_sel
);
    localparam int BASE_W = ADDR_W - SLOT_W;
    localparam int RSV_W  = DATA_W - BASE_W - 1;

    logic [BASE_W-1:0] base;
    logic              flag;
    lock_state_e       lock_state;
    logic              hit;
    logic [WIN_W-1:0]  offset;
    logic              ctl_hit;

    regwin_match #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .WIN_W(WIN_W)) u_match (
        .addr(addr), .base(base), .hit(hit), .offset(offset)
    );

    assign ctl_hit = hit && (offset == WIN_W'(CTL_OFS));

    regwin_ctl #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .special(mode_special),
        .wr_hit(wr_en && ctl_hit), .wdata(wdata),
        .base(base), .flag(flag), .lock_state(lock_state)
    );

    regwin_port #(.WIN_W(WIN_W), .PORT_OFS(PORT_OFS), .PORT_CNT(PORT_CNT)) u_port (
        .hit(hit), .offset(offset), .expanded(mode_expanded), .emul(port_emul),
        .blk_sel(blk_sel), .port_sel(port_sel)
    );

    assign blk_offset = offset;
    assign ctl_rdata  = (rd_en && ctl_hit) ? {base, {RSV_W{1'b0}}, flag} : '0;

    assert_port_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_sel |-> blk_sel);
    assert_single_chip_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_expanded && hit && int'(offset) >= PORT_OFS && int'(offset) < PORT_OFS + PORT_CNT)
        |-> port_sel);
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[RSV_W:1] == '0);
    assert_ctl_reads_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata != '0) |-> (blk_sel && addr[SLOT_W-1:WIN_W] == '0));
endmodule

// File: tb/test_regwin_decoder.sv
module test_regwin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        mode_special = 1'b0, mode_expanded = 1'b0, port_emul = 1'b0;
    logic        blk_sel, port_sel;
    logic [8:0]  blk_offset;
    logic [7:0]  ctl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    regwin_decoder i_regwin_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .mode_special(mode_special), .mode_expanded(mode_expanded),
        .port_emul(port_emul), .blk_sel(blk_sel), .blk_offset(blk_offset),
        .ctl_rdata(ctl_rdata), .port_sel(port_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_ctl(input logic [15:0] a, input string tag, input int exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        chk(tag, ctl_rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input string tag, input int sel, input int psel);
        @(negedge clk);
        addr = a;
        #1;
        chk({tag, " blk_sel"}, blk_sel, sel);
        chk({tag, " port_sel"}, port_sel, psel);
        if (sel == 1) chk({tag, " offset"}, blk_offset, a[8:0]);
    endtask

    task automatic t_reset();
        do_reset();
        read_ctl(16'h0014, "R1 ctl after reset", 8'h00);
        probe(16'h0000, "R1 base 0", 1, 0);
        probe(16'h01FF, "R2 top of window", 1, 0);
        probe(16'h0200, "R3 dead zone", 0, 0);
        probe(16'h0800, "R2 next slot", 0, 0);
    endtask

    task automatic t_normal_once();
        mode_special = 1'b0;
        read_ctl(16'h0014, "R9 read before write", 8'h00);
        read_ctl(16'h0014, "R9 second read", 8'h00);
        do_write(16'h0014, 8'h4F);
        read_ctl(16'h4814, "R6 R7 ctl at new base", 8'h49);
        probe(16'h0000, "R7 old base dark", 0, 0);
        probe(16'h4800, "R7 new base", 1, 0);
        probe(16'h49FF, "R2 new top", 1, 0);
        probe(16'h4A00, "R3 dead zone new", 0, 0);
        probe(16'h4FFF, "R3 slot end", 0, 0);
        do_write(16'h4814, 8'h10);
        read_ctl(16'h4814, "R4 second write ignored", 8'h49);
        read_ctl(16'h1014, "R4 no move", 8'h00);
    endtask

    task automatic t_special();
        mode_special = 1'b1;
        do_write(16'h4814, 8'h81);
        read_ctl(16'h8014, "R5 special write", 8'h81);
        do_write(16'h8014, 8'h06);
        read_ctl(16'h0014, "R5 R6 special again", 8'h00);
        do_reset();
        mode_special = 1'b1;
        do_write(16'h0014, 8'h20);
        read_ctl(16'h2014, "R5 special before seal", 8'h20);
        mode_special = 1'b0;
        do_write(16'h2014, 8'h30);
        read_ctl(16'h3014, "R5 lock left open", 8'h30);
        do_write(16'h3014, 8'h40);
        read_ctl(16'h3014, "R4 sealed after normal", 8'h30);
    endtask

    task automatic t_port();
        mode_expanded = 1'b1; port_emul = 1'b0;
        probe(16'h3008, "R8 expanded mapped", 1, 1);
        probe(16'h3009, "R8 expanded mapped hi", 1, 1);
        port_emul = 1'b1;
        probe(16'h3008, "R8 removed", 0, 0);
        probe(16'h3009, "R8 removed hi", 0, 0);
        probe(16'h300A, "R8 neighbour kept", 1, 0);
        mode_expanded = 1'b0;
        probe(16'h3008, "R8 single-chip kept", 1, 1);
        probe(16'h0008, "R8 outside window", 0, 0);
    endtask

    initial begin
        t_reset();
        t_normal_once();
        t_special();
        t_port();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule